// File: doc/BRIEF.md
# LCD Row Scan Sequencer

This block produces the time-multiplexed row drive pattern for a 40-output dot-matrix LCD driver. The oscillator clock is divided into a cascade clock (CLK) for column drivers further down the chain. A frame-start pulse (SYNC) is generated from that clock. The row select then steps through the rows that the chosen multiplex rate makes active. The block also reports, for each output, whether that output carries column data, so that the column data path and the analog drivers know the role of every pin.

Four multiplex rates are supported: 1:8, 1:16, 1:24 and 1:32. Each rate can run in row mode, where all of outputs 0–31 are rows, or in mixed mode, where the programmable outputs beyond the last row carry columns. At 1:16 and 1:8 the select is copied onto several output groups to drive split-screen panels. A new rate or mode is taken only at a frame boundary, so every frame is complete and consistent. A blank input suppresses all row selects, and the outputs keep their roles while it is set.

Top module: `lcd_row_scan`

## Requirements
- R1: The reset input is synchronous and active high. While it is high, every output is 0. After reset the active configuration is 1:32 in row mode and the display is blanked: `row_sel` stays 0 until a low `blank` has been sampled. This configuration holds for the whole first frame, whatever `rate_sel` and `row_mode` carry.
- R2: `clk_out` is the oscillator divided by 6 when the active rate code is 00, 01 or 11, and divided by 8 when it is 10. It is high for the first half of each period.
- R3: Each row slot lasts SLOT_CLKS (default 2) `clk_out` periods. The row index starts at 0, rises by one per slot, and wraps to 0 after the last active row. A frame therefore lasts rows × SLOT_CLKS × divider oscillator cycles.
- R4: `sync_out` is high for exactly the first `clk_out` period of each frame (row 0, first slot), and it rises together with `clk_out`.
- R5: The rate code selects the active rows: 00 selects outputs 0–7 (1:8), 01 selects 0–15 (1:16), 10 selects 0–23 (1:24) and 11 selects 0–31 (1:32).
- R6: For row index n, output n is selected. At 1:16, outputs n and n+16 are selected. At 1:8, outputs n, n+8, n+16 and n+24 are selected. A copy is driven only on outputs that currently act as rows. Outputs 32–39 are never selected.
- R7: `is_col` bit i is set only in mixed mode (`row_mode` = 0), and only for outputs i ≥ the active row count, including all of 32–39. In row mode `is_col` is all zero: outputs 0–31 are rows and 32–39 are unused. Outputs 0–7 are never columns.
- R8: `blank` = 1 forces `row_sel` to all zero from the second oscillator edge after it is applied. `clk_out`, `sync_out` and `is_col` continue unchanged.
- R9: `rate_sel` and `row_mode` are sampled only on the oscillator edge that ends the last slot of a frame. At that point the row index restarts at 0, and changes made mid-frame have no effect on the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Multiplex rate code: 00 1:8, 01 1:16, 10 1:24, 11 1:32 |
| row_mode | input | 1 | 1 = row mode, 0 = mixed mode |
| blank | input | 1 | 1 = suppress all row selects |
| row_sel | output | 40 | Row-select vector, one bit per driver output |
| is_col | output | 40 | 1 where the output carries column data |
| clk_out | output | 1 | Divided cascade clock |
| sync_out | output | 1 | Frame-start pulse, one `clk_out` period wide |

## Verification
Each of the eight rate and mode combinations is held for complete frames. The measured frame length separates the two divider ratios and the four row counts, and the per-output compare separates split-screen copies in row mode from their suppression in mixed mode. The first frame after reset runs with rate and mode inputs that differ from the reset configuration, and random runs change those inputs in the middle of frames. A design that takes the configuration at once, rather than at the boundary, produces a different pattern there. Random blank windows and resets in mid-frame test the blanking delay and the restart of the scan.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Multiplex rate code; the numeric value + 1 is the active row count in groups
  typedef enum logic [1:0] {
    MUX8  = 2'b00,
    MUX16 = 2'b01,
    MUX24 = 2'b10,
    MUX32 = 2'b11
  } mux_rate_e;

  typedef struct packed {
    mux_rate_e rate;
    logic      row_mode;
  } scan_cfg_t;

  localparam scan_cfg_t CFG_RESET = '{rate: MUX32, row_mode: 1'b1};

endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler
  import lcd_scan_pkg::*;
#(
  parameter int DIV_STD = 6,
  parameter int DIV_ALT = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  mux_rate_e rate,
  output logic      tick,
  output logic      clk_lvl
);

  localparam int DIV_MAX = (DIV_STD > DIV_ALT) ? DIV_STD : DIV_ALT;
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] half;

  // the 1:24 rate uses the alternate ratio so its frame rate stays close
  always_comb begin
    if (rate == MUX24) div_m1 = CNT_W'(DIV_ALT - 1);
    else               div_m1 = CNT_W'(DIV_STD - 1);
    half = CNT_W'((int'(div_m1) + 1) / 2);
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (cnt == div_m1) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick    = (cnt == div_m1);
  assign clk_lvl = (cnt < half);

endmodule

// File: rtl/lcd_row_counter.sv
module lcd_row_counter
  import lcd_scan_pkg::*;
#(
  parameter int GRP       = 8,
  parameter int MAX_ROWS  = 32,
  parameter int SLOT_CLKS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick,
  input  logic [1:0]                  rate_in,
  input  logic                        mode_in,
  output scan_cfg_t                   cfg,
  output logic [$clog2(MAX_ROWS)-1:0] row,
  output logic                        frame_start
);

  localparam int ROW_W  = $clog2(MAX_ROWS);
  localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  logic [SLOT_W-1:0] slot;
  logic [ROW_W-1:0]  last_row;
  logic              slot_end;
  logic              frame_end;

  always_comb begin
    last_row  = ROW_W'(GRP * (int'(cfg.rate) + 1) - 1);
    slot_end  = tick && (slot == SLOT_W'(SLOT_CLKS - 1));
    frame_end = slot_end && (row == last_row);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= CFG_RESET;
      slot <= '0;
      row  <= '0;
    end else if (tick) begin
      if (slot_end) begin
        slot <= '0;
        if (frame_end) begin
          row          <= '0;
          cfg.rate     <= mux_rate_e'(rate_in);
          cfg.row_mode <= mode_in;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign frame_start = (row == '0) && (slot == '0);

endmodule

// File: rtl/lcd_drive_decoder.sv
module lcd_drive_decoder
  import lcd_scan_pkg::*;
#(
  parameter int N_OUT    = 40,
  parameter int GRP      = 8,
  parameter int MAX_ROWS = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  scan_cfg_t                   cfg,
  input  logic [$clog2(MAX_ROWS)-1:0] row,
  input  logic                        blank_q,
  input  logic                        clk_lvl,
  input  logic                        frame_start,
  output logic [N_OUT-1:0]            row_sel,
  output logic [N_OUT-1:0]            is_col,
  output logic                        clk_out,
  output logic                        sync_out
);

  int               nrows;
  logic [N_OUT-1:0] hit;
  logic [N_OUT-1:0] is_row;
  logic [N_OUT-1:0] col_n;
  logic [N_OUT-1:0] sel_n;

  assign nrows = GRP * (int'(cfg.rate) + 1);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (i < GRP) begin : g_fixed_row
      assign is_row[i] = 1'b1;
      assign col_n[i]  = 1'b0;
    end else if (i < MAX_ROWS) begin : g_prog
      assign is_row[i] = cfg.row_mode || (i < nrows);
      assign col_n[i]  = !cfg.row_mode && (i >= nrows);
    end else begin : g_fixed_col
      assign is_row[i] = 1'b0;
      assign col_n[i]  = !cfg.row_mode;
    end

    if (i < MAX_ROWS) begin : g_hit
      // split-screen copies: period GRP at 1:8, 2*GRP at 1:16, none otherwise
      assign hit[i] = (cfg.rate == MUX8)  ? (int'(row) == (i % GRP)) :
                      (cfg.rate == MUX16) ? (int'(row) == (i % (2 * GRP))) :
                                            (int'(row) == i);
    end else begin : g_nohit
      assign hit[i] = 1'b0;
    end

    assign sel_n[i] = !blank_q && is_row[i] && hit[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_sel  <= '0;
      is_col   <= '0;
      clk_out  <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      row_sel  <= sel_n;
      is_col   <= col_n;
      clk_out  <= clk_lvl;
      sync_out <= frame_start;
    end
  end

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int N_OUT     = 40,
  parameter int GRP       = 8,
  parameter int MAX_ROWS  = 32,
  parameter int SLOT_CLKS = 2,
  parameter int DIV_STD   = 6,
  parameter int DIV_ALT   = 8
) (
  input  logic             osc_clk,
  input  logic             rst,
  input  logic [1:0]       rate_sel,
  input  logic             row_mode,
  input  logic             blank,
  output logic [N_OUT-1:0] row_sel,
  output logic [N_OUT-1:0] is_col,
  output logic             clk_out,
  output logic             sync_out
);

  localparam int ROW_W = $clog2(MAX_ROWS);

  scan_cfg_t        cfg;
  logic [ROW_W-1:0] row;
  logic             tick;
  logic             clk_lvl;
  logic             frame_start;
  logic             blank_q;

  always_ff @(posedge osc_clk) begin
    if (rst) blank_q <= 1'b1;
    else     blank_q <= blank;
  end

  lcd_prescaler #(
    .DIV_STD (DIV_STD),
    .DIV_ALT (DIV_ALT)
  ) u_presc (
    .clk     (osc_clk),
    .rst     (rst),
    .rate    (cfg.rate),
    .tick    (tick),
    .clk_lvl (clk_lvl)
  );

  lcd_row_counter #(
    .GRP       (GRP),
    .MAX_ROWS  (MAX_ROWS),
    .SLOT_CLKS (SLOT_CLKS)
  ) u_rows (
    .clk         (osc_clk),
    .rst         (rst),
    .tick        (tick),
    .rate_in     (rate_sel),
    .mode_in     (row_mode),
    .cfg         (cfg),
    .row         (row),
    .frame_start (frame_start)
  );

  lcd_drive_decoder #(
    .N_OUT    (N_OUT),
    .GRP      (GRP),
    .MAX_ROWS (MAX_ROWS)
  ) u_dec (
    .clk         (osc_clk),
    .rst         (rst),
    .cfg         (cfg),
    .row         (row),
    .blank_q     (blank_q),
    .clk_lvl     (clk_lvl),
    .frame_start (frame_start),
    .row_sel     (row_sel),
    .is_col      (is_col),
    .clk_out     (clk_out),
    .sync_out    (sync_out)
  );

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int N_OUT    = 40,
  parameter int GRP      = 8,
  parameter int MAX_ROWS = 32
) (
  input logic             osc_clk,
  input logic             rst,
  input logic             blank,
  input logic [N_OUT-1:0] row_sel,
  input logic [N_OUT-1:0] is_col,
  input logic             clk_out,
  input logic             sync_out
);

  // R6
  sel_not_col_chk: assert property (@(posedge osc_clk) disable iff (rst)
    (row_sel & is_col) == '0);

  // R6
  fixed_col_unselected_chk: assert property (@(posedge osc_clk) disable iff (rst)
    row_sel[N_OUT-1:MAX_ROWS] == '0);

  // R6
  copies_bounded_chk: assert property (@(posedge osc_clk) disable iff (rst)
    ($countones(row_sel) <= 4) && $onehot0(row_sel[GRP-1:0]));

  // R7
  fixed_rows_chk: assert property (@(posedge osc_clk) disable iff (rst)
    is_col[GRP-1:0] == '0);

  // R8
  blank_chk: assert property (@(posedge osc_clk) disable iff (rst)
    $past(blank, 2) |-> (row_sel == '0));

  // R4
  sync_edge_chk: assert property (@(posedge osc_clk) disable iff (rst)
    $rose(sync_out) |-> $rose(clk_out));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(
  .N_OUT    (N_OUT),
  .GRP      (GRP),
  .MAX_ROWS (MAX_ROWS)
) u_chk (
  .osc_clk  (osc_clk),
  .rst      (rst),
  .blank    (blank),
  .row_sel  (row_sel),
  .is_col   (is_col),
  .clk_out  (clk_out),
  .sync_out (sync_out)
);

// File: tb/tb_lcd_row_scan.sv
module tb_lcd_row_scan;

  localparam int N_OUT = 40;
  localparam int SLOT  = 2;

  logic             osc_clk  = 1'b0;
  logic             rst      = 1'b1;
  logic [1:0]       rate_sel = 2'd3;
  logic             row_mode = 1'b1;
  logic             blank    = 1'b1;
  logic [N_OUT-1:0] row_sel;
  logic [N_OUT-1:0] is_col;
  logic             clk_out;
  logic             sync_out;

  int vectors = 0;
  int fails   = 0;

  always #4 osc_clk = ~osc_clk;

  lcd_row_scan dut (
    .osc_clk  (osc_clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .row_mode (row_mode),
    .blank    (blank),
    .row_sel  (row_sel),
    .is_col   (is_col),
    .clk_out  (clk_out),
    .sync_out (sync_out)
  );

  // reference state built from the requirements
  int m_div, m_slot, m_row, m_rate, m_mode, m_blank;
  logic [N_OUT-1:0] exp_sel, exp_col;
  logic exp_clk, exp_sync;

  function automatic int rows_of(int rate);
    return 8 * (rate + 1);                           // R5
  endfunction

  function automatic int div_of(int rate);
    return (rate == 2) ? 8 : 6;                      // R2
  endfunction

  function automatic logic [N_OUT-1:0] f_sel(int rate, int mode, int row, int blk);
    logic [N_OUT-1:0] v = '0;
    for (int i = 0; i < 32; i++) begin
      bit row_role = (i < 8) || (mode != 0) || (i < rows_of(rate));
      bit match    = (rate == 0) ? ((i % 8) == row) :
                     (rate == 1) ? ((i % 16) == row) : (i == row);
      v[i] = (blk == 0) && row_role && match;        // R6 R8
    end
    return v;
  endfunction

  function automatic logic [N_OUT-1:0] f_col(int rate, int mode);
    logic [N_OUT-1:0] v = '0;
    for (int i = 8; i < N_OUT; i++)
      v[i] = (mode == 0) && (i >= rows_of(rate));    // R7
    return v;
  endfunction

  always @(posedge osc_clk) begin
    if (rst) begin
      exp_sel = '0; exp_col = '0; exp_clk = 1'b0; exp_sync = 1'b0;
      m_div = 0; m_slot = 0; m_row = 0; m_rate = 3; m_mode = 1; m_blank = 1;  // R1
    end else begin
      exp_sel  = f_sel(m_rate, m_mode, m_row, m_blank);
      exp_col  = f_col(m_rate, m_mode);
      exp_clk  = (m_div < div_of(m_rate) / 2);
      exp_sync = (m_row == 0) && (m_slot == 0);
      if (m_div == div_of(m_rate) - 1) begin
        m_div = 0;
        if (m_slot == SLOT - 1) begin
          m_slot = 0;
          if (m_row == rows_of(m_rate) - 1) begin    // R9
            m_row  = 0;
            m_rate = int'(rate_sel);
            m_mode = int'(row_mode);
          end else m_row++;
        end else m_slot++;
      end else m_div++;
      m_blank = int'(blank);
    end
  end

  always @(negedge osc_clk) begin
    vectors++;
    if (row_sel !== exp_sel) begin
      fails++;
      $display("FAIL R3 R5 R6 R8 R9 row_sel actual=%h expected=%h", row_sel, exp_sel);
    end
    if (is_col !== exp_col) begin
      fails++;
      $display("FAIL R7 is_col actual=%h expected=%h", is_col, exp_col);
    end
    if (clk_out !== exp_clk) begin
      fails++;
      $display("FAIL R2 clk_out actual=%b expected=%b", clk_out, exp_clk);
    end
    if (sync_out !== exp_sync) begin
      fails++;
      $display("FAIL R4 sync_out actual=%b expected=%b", sync_out, exp_sync);
    end
  end

  task automatic wait_sync_rise();
    logic prev = sync_out;
    forever begin
      @(negedge osc_clk);
      if (sync_out && !prev) break;
      prev = sync_out;
    end
  endtask

  task automatic measure_frame(input int exp_len);
    logic prev;
    int   n = 0;
    wait_sync_rise();
    prev = sync_out;
    forever begin
      @(negedge osc_clk);
      n++;
      if (sync_out && !prev) break;
      prev = sync_out;
    end
    vectors++;
    if (n != exp_len) begin
      fails++;
      $display("FAIL R3 R9 frame length actual=%0d expected=%0d", n, exp_len);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge osc_clk);
    // R1: first frame must ignore inputs that differ from the reset configuration
    rate_sel = 2'd0;
    row_mode = 1'b0;
    rst      = 1'b0;
    repeat (20) @(negedge osc_clk);
    vectors++;
    if (row_sel !== '0 || is_col !== '0) begin
      fails++;
      $display("FAIL R1 after reset actual=%h/%h expected=0/0", row_sel, is_col);
    end
    blank = 1'b0;
    // directed: every rate and mode held for full frames
    for (int md = 0; md < 2; md++) begin
      for (int rt = 0; rt < 4; rt++) begin
        rate_sel = 2'(rt);
        row_mode = md[0];
        measure_frame(rows_of(rt) * SLOT * div_of(rt));
        repeat (50) @(negedge osc_clk);
      end
    end
    // random: mid-frame changes, blank windows, occasional reset
    repeat (150) begin
      repeat (($urandom % 300) + 1) @(negedge osc_clk);
      rate_sel = 2'($urandom % 4);
      row_mode = 1'($urandom % 2);
      blank    = (($urandom % 6) == 0);
      if (($urandom % 40) == 0) begin
        rst = 1'b1;
        repeat (3) @(negedge osc_clk);
        rst = 1'b0;
      end
    end
    repeat (20) @(negedge osc_clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge osc_clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule